// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is one timer channel that counts down from a programmed value at the input clock rate. A simple bus with valid, write, word-index and data lines gives software access to it. Software chooses a run mode (free-running, periodic or one-shot), a counter width of 16 or 32 bits, and a prescaler of 1, 16 or 256. When the counter reaches zero the block raises an internal raw flag. A level interrupt reports that flag when the interrupt is enabled, and a write to a clear slot lowers it.

There are two ways to write the reload value. The immediate slot stores the value and restarts the count at once. The background slot stores the value only, and the counter takes it up at its next natural reload. In free-running mode the stored value is not used: the counter always restarts from all ones at the selected width.

Reads are combinational from the word index. A write takes effect on the rising clock edge at which valid and write are both high.

Top module: `cdtimer`

## Requirements
- R1: After reset the control word reads 0x20 (interrupt enable set, timer stopped). The count, the stored reload value and the raw flag read zero, and the interrupt output is low.
- R2: Word indices are 0 immediate reload, 1 count, 2 control, 3 flag clear, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 background reload. Indices 0 and 6 both read the stored reload value. Indices 3 and 7 read zero. Control bits are 7 run, 6 periodic, 5 interrupt enable, 4 reads zero, 3:2 prescale, 1 wide (32-bit), 0 one-shot.
- R3: A write to index 0 stores the value and loads the counter on the same edge with the mode's reload value. It also restarts the prescaler.
- R4: A write to index 6 stores the value without touching the counter. The counter uses the new value at its next reload.
- R5: Prescale code 0 or 3 decrements once per clock, code 1 once per 16 clocks and code 2 once per 256 clocks. After a restart of the prescaler, the first decrement comes after a full period.
- R6: In periodic mode a decrement from 1 to 0 sets the raw flag. The next decrement reloads the stored value and counting continues.
- R7: In one-shot mode (bit 0 set) the counter stays at zero until a reload write or a control write with the run bit set.
- R8: With bits 6 and 0 both clear the timer is free-running. It loads and reloads 0xFFFF when narrow and 0xFFFFFFFF when wide, whatever the stored value holds.
- R9: In 16-bit mode only the low 16 bits count. The count reads with bits 31:16 zero, and a 16-bit reload keeps only the low 16 bits of the stored value.
- R10: A control write with the run bit set loads the counter and restarts the prescaler. While the run bit is clear the count holds.
- R11: Writes to index 1 have no effect on the count.
- R12: Any write to index 3 clears the raw flag. If that write lands on the edge where the count reaches zero, the flag stays set.
- R13: The masked flag and the interrupt output equal the raw flag ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access valid |
| busWrite | input | 1 | Access is a write when high |
| busAddr | input | ADDR_W (3) | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Level interrupt: raw flag AND enable |

## Verification
Two events can fall on the same edge: a flag-clear write and the decrement that takes the count from 1 to 0. The bench sets up the collision by loading 2 in periodic mode, idling one clock, and then issuing the clear write so that it lands on the terminal edge. It judges the result by reading the raw flag as 1 afterwards and as 0 after a second clear. A second collision is a background reload write on a decrement edge, and there the count must still decrement while the stored value changes.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 8;
  localparam int NUM_SLOTS = 7;

  localparam int IDX_LOAD = 0;
  localparam int IDX_VALUE = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_ICLR = 3;
  localparam int IDX_RAW = 4;
  localparam int IDX_MASK = 5;
  localparam int IDX_BGLD = 6;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV16  = 2'd1,
    PRE_DIV256 = 2'd2,
    PRE_RSVD   = 2'd3
  } preSel_e;

  // Packed with bit 7 first so that the struct matches the control word.
  typedef struct packed {
    logic    enable;
    logic    periodic;
    logic    intEn;
    logic    rsvd;
    preSel_e preSel;
    logic    wide;
    logic    oneShot;
  } ctrl_t;

  // Control to datapath strobes.
  typedef struct packed {
    logic              reloadNow;
    logic              preClear;
    logic [DATA_W-1:0] reloadVal;
  } strobe_t;

  localparam ctrl_t CTRL_RST = '{enable: 1'b0, periodic: 1'b0, intEn: 1'b1,
                                 rsvd: 1'b0, preSel: PRE_DIV1, wide: 1'b0,
                                 oneShot: 1'b0};
endpackage

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
  import cdtimer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] countVal,
  input  logic              hitZero,
  output ctrl_t             ctrl,
  output strobe_t           strobe,
  output logic              rawFlag,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [NUM_SLOTS-1:0] hit;
  logic                 wrEn;
  ctrl_t                ctrlQ;
  ctrl_t                wdCtrl;
  ctrl_t                effCtrl;
  logic [DATA_W-1:0]    loadQ;
  logic [DATA_W-1:0]    effLoad;
  logic [DATA_W-1:0]    reloadRaw;
  logic                 rawQ;
  logic                 freeRun;

  // One-hot word decode.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
    assign hit[i] = (busAddr == ADDR_W'(i));
  end

  assign wrEn = busValid && busWrite;

  always_comb begin
    wdCtrl      = ctrl_t'(busWdata[CTRL_W-1:0]);
    wdCtrl.rsvd = 1'b0;
  end

  // Control, load and flag registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RST;
      loadQ <= '0;
      rawQ  <= 1'b0;
    end else begin
      if (wrEn && hit[IDX_CTRL]) ctrlQ <= wdCtrl;
      if (wrEn && (hit[IDX_LOAD] || hit[IDX_BGLD])) loadQ <= busWdata;
      if (hitZero) rawQ <= 1'b1;
      else if (wrEn && hit[IDX_ICLR]) rawQ <= 1'b0;
    end
  end

  // Reload value seen from the settings that hold after this edge.
  always_comb begin
    effCtrl   = (wrEn && hit[IDX_CTRL]) ? wdCtrl : ctrlQ;
    effLoad   = (wrEn && (hit[IDX_LOAD] || hit[IDX_BGLD])) ? busWdata : loadQ;
    freeRun   = !effCtrl.periodic && !effCtrl.oneShot;
    reloadRaw = freeRun ? ALL_ONES : effLoad;
    strobe.reloadVal = effCtrl.wide ? reloadRaw : (reloadRaw & NARROW_MASK);
    strobe.reloadNow = wrEn && (hit[IDX_LOAD] || (hit[IDX_CTRL] && wdCtrl.enable));
    strobe.preClear  = wrEn && (hit[IDX_LOAD] || hit[IDX_CTRL]);
  end

  // Read mux.
  always_comb begin
    busRdata = '0;
    if (hit[IDX_LOAD] || hit[IDX_BGLD]) busRdata = loadQ;
    else if (hit[IDX_VALUE])            busRdata = countVal;
    else if (hit[IDX_CTRL])             busRdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
    else if (hit[IDX_RAW])              busRdata = {{(DATA_W-1){1'b0}}, rawQ};
    else if (hit[IDX_MASK])             busRdata = {{(DATA_W-1){1'b0}}, rawQ && ctrlQ.intEn};
  end

  assign ctrl    = ctrlQ;
  assign rawFlag = rawQ;
  assign irqOut  = rawQ && ctrlQ.intEn;
endmodule

// File: rtl/cdtimer_count.sv
module cdtimer_count
  import cdtimer_pkg::*;
#(
  parameter int NARROW_W    = 16,
  parameter int PRE_MID_LOG = 4,
  parameter int PRE_HI_LOG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] countVal,
  output logic              hitZero
);
  localparam int PRE_W = PRE_HI_LOG;
  localparam logic [PRE_W-1:0] MAX_MID = {{(PRE_W-PRE_MID_LOG){1'b0}}, {PRE_MID_LOG{1'b1}}};
  localparam logic [PRE_W-1:0] MAX_HI  = '1;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preMax;
  logic              tick;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] nextCount;

  always_comb begin
    case (ctrl.preSel)
      PRE_DIV16:  preMax = MAX_MID;
      PRE_DIV256: preMax = MAX_HI;
      default:    preMax = '0;
    endcase
  end

  assign tick = ctrl.enable && !strobe.preClear && (preCnt == preMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          preCnt <= '0;
    else if (strobe.preClear || tick)   preCnt <= '0;
    else if (ctrl.enable)               preCnt <= preCnt + 1'b1;
  end

  assign cur = ctrl.wide ? countQ : (countQ & NARROW_MASK);

  always_comb begin
    nextCount = countQ;
    hitZero   = 1'b0;
    if (strobe.reloadNow) begin
      nextCount = strobe.reloadVal;
    end else if (tick) begin
      if (cur == '0) begin
        if (!ctrl.oneShot) nextCount = strobe.reloadVal;
      end else begin
        nextCount = cur - ONE;
        hitZero   = (cur == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= nextCount;
  end

  assign countVal = cur;
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int NARROW_W    = 16,
  parameter int PRE_MID_LOG = 4,
  parameter int PRE_HI_LOG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  ctrl_t             ctrlW;
  strobe_t           stW;
  logic [DATA_W-1:0] countW;
  logic              hitW;
  logic              rawW;

  cdtimer_regs #(
    .ADDR_W  (ADDR_W),
    .NARROW_W(NARROW_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .countVal(countW),
    .hitZero (hitW),
    .ctrl    (ctrlW),
    .strobe  (stW),
    .rawFlag (rawW),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );

  cdtimer_count #(
    .NARROW_W   (NARROW_W),
    .PRE_MID_LOG(PRE_MID_LOG),
    .PRE_HI_LOG (PRE_HI_LOG)
  ) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlW),
    .strobe  (stW),
    .countVal(countW),
    .hitZero (hitW)
  );
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk
  import cdtimer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] countVal,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic              rawFlag,
  input logic              hitZero,
  input logic              irqOut
);
  logic wr;
  logic clrWr;
  logic cntZero;
  assign wr      = busValid && busWrite;
  assign clrWr   = wr && (busAddr == ADDR_W'(IDX_ICLR));
  assign cntZero = ctrlBits[1] ? (countVal == '0) : (countVal[NARROW_W-1:0] == '0);

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrlBits[5]); // R13
  AST_HIT_SETS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    hitZero |=> rawFlag); // R6
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !hitZero) |=> !rawFlag); // R12
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && hitZero) |=> rawFlag); // R12
  AST_VALUE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(IDX_VALUE) && !ctrlBits[7]) |=> $stable(countVal)); // R11
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!wr && !ctrlBits[7]) |=> $stable(countVal)); // R10
  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (!wr && ctrlBits[7] && ctrlBits[0] && cntZero) |=> $stable(countVal)); // R7
  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(IDX_VALUE) && !ctrlBits[1]) |-> (busRdata[DATA_W-1:NARROW_W] == '0)); // R9
endmodule

bind cdtimer cdtimer_chk #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .countVal(countW),
  .ctrlBits(ctrlW),
  .rawFlag (rawW),
  .hitZero (hitW),
  .irqOut  (irqOut)
);

// File: tb/cdtimer_test.sv
module cdtimer_test;
  localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5, A_BG = 3'd6, A_NONE = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        irqOut;

  always #10 clk = ~clk;

  cdtimer uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       expQ[$];
  item_t       curItem;
  logic [31:0] act;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  event        pushEv;

  // Driver side: queue an expectation and present the address.
  task automatic pushCheck(input bit isIrq, input logic [2:0] idx,
                           input logic [31:0] exp, input string tag);
    item_t it;
    if (!isIrq) busAddr = idx;
    it.isIrq = isIrq;
    it.exp   = exp;
    it.tag   = tag;
    expQ.push_back(it);
    -> pushEv;
    #2;
  endtask

  task automatic chkReg(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    pushCheck(1'b0, idx, exp, tag);
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    pushCheck(1'b1, A_NONE, {31'd0, exp}, tag);
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = idx; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: pop and compare.
  initial begin
    forever begin
      @(pushEv);
      #1;
      while (expQ.size() != 0) begin
        curItem = expQ.pop_front();
        act = curItem.isIrq ? {31'd0, irqOut} : busRdata;
        checks++;
        if (act !== curItem.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", curItem.tag, act, curItem.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    chkReg(A_CTRL, 32'h20, "R1 control after reset");
    chkReg(A_VAL, 32'h0, "R1 count after reset");
    chkReg(A_LOAD, 32'h0, "R1 load after reset");
    chkReg(A_RAW, 32'h0, "R1 raw after reset");
    idle(1);
    chkIrq(1'b0, "R1 irq after reset");
    chkReg(A_NONE, 32'h0, "R2 index 7 reads zero");
    chkReg(A_CLR, 32'h0, "R2 index 3 reads zero");

    // Periodic, div 1, wide
    wr(A_LOAD, 32'd10);
    chkReg(A_VAL, 32'h0000FFFF, "R8 load write in free mode gives full count");
    chkReg(A_LOAD, 32'd10, "R2 index 0 reads stored value");
    chkReg(A_BG, 32'd10, "R2 index 6 reads stored value");
    wr(A_CTRL, 32'hE2);
    chkReg(A_VAL, 32'd10, "R10 enable write reloads");
    chkReg(A_CTRL, 32'hE2, "R2 control readback");
    idle(9);
    chkReg(A_VAL, 32'd1, "R5 div1 count after 9 clocks");
    chkReg(A_RAW, 32'd0, "R6 raw before zero");
    idle(1);
    chkReg(A_VAL, 32'd0, "R6 count at zero");
    chkReg(A_RAW, 32'd1, "R6 raw set at zero");
    chkReg(A_MSK, 32'd1, "R13 masked with enable");
    idle(1);
    chkIrq(1'b1, "R13 irq with enable");
    chkReg(A_VAL, 32'd10, "R6 periodic reload");

    // Masking
    wr(A_CTRL, 32'hC2);
    chkReg(A_RAW, 32'd1, "R13 raw kept when mask off");
    chkReg(A_MSK, 32'd0, "R13 masked zero when enable off");
    idle(1);
    chkIrq(1'b0, "R13 irq low when enable off");

    // Clear
    wr(A_CLR, 32'hDEAD);
    chkReg(A_RAW, 32'd0, "R12 clear drops raw");

    // Clear on terminal edge
    wr(A_LOAD, 32'd2);
    chkReg(A_VAL, 32'd2, "R3 load write reloads at once");
    idle(1);
    wr(A_CLR, 32'd0);
    chkReg(A_VAL, 32'd0, "R12 count reached zero on clear edge");
    chkReg(A_RAW, 32'd1, "R12 set wins over clear");
    wr(A_CLR, 32'd0);
    chkReg(A_RAW, 32'd0, "R12 later clear drops raw");
    chkReg(A_VAL, 32'd2, "R6 reload after clear");

    // Background reload
    wr(A_LOAD, 32'd3);
    wr(A_BG, 32'd5);
    chkReg(A_VAL, 32'd2, "R4 background write leaves count");
    chkReg(A_LOAD, 32'd5, "R4 index 0 shows new value");
    chkReg(A_BG, 32'd5, "R4 index 6 shows new value");
    idle(2);
    chkReg(A_VAL, 32'd0, "R4 count runs down to zero");
    idle(1);
    chkReg(A_VAL, 32'd5, "R4 next reload uses background value");

    // Halt and value-write ignored
    wr(A_CTRL, 32'h42);
    chkReg(A_VAL, 32'd5, "R10 disable holds count");
    wr(A_VAL, 32'h1234);
    chkReg(A_VAL, 32'd5, "R11 value write ignored");
    idle(3);
    chkReg(A_VAL, 32'd5, "R10 count holds while stopped");

    // Prescalers
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'hC6);
    chkReg(A_VAL, 32'd3, "R5 div16 start");
    idle(15);
    chkReg(A_VAL, 32'd3, "R5 div16 no step before 16");
    idle(1);
    chkReg(A_VAL, 32'd2, "R5 div16 step at 16");
    wr(A_CTRL, 32'hCA);
    idle(255);
    chkReg(A_VAL, 32'd3, "R5 div256 no step before 256");
    idle(1);
    chkReg(A_VAL, 32'd2, "R5 div256 step at 256");
    wr(A_CTRL, 32'hCE);
    idle(1);
    chkReg(A_VAL, 32'd2, "R5 code 3 divides by 1");

    // One-shot
    wr(A_CLR, 32'd0);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'hA3);
    idle(2);
    chkReg(A_VAL, 32'd0, "R7 one-shot reaches zero");
    chkReg(A_RAW, 32'd1, "R7 one-shot sets raw");
    idle(5);
    chkReg(A_VAL, 32'd0, "R7 one-shot parks at zero");
    wr(A_LOAD, 32'd4);
    idle(1);
    chkReg(A_VAL, 32'd3, "R7 reload restarts one-shot");

    // 16-bit width
    wr(A_CTRL, 32'hE0);
    wr(A_LOAD, 32'h0001_2345);
    chkReg(A_VAL, 32'h0000_2345, "R9 narrow count drops upper bits");
    chkReg(A_LOAD, 32'h0001_2345, "R9 stored value keeps upper bits");
    idle(1);
    chkReg(A_VAL, 32'h0000_2344, "R9 narrow count decrements");

    // Free-running 16-bit wrap
    wr(A_CLR, 32'd0);
    wr(A_CTRL, 32'hA0);
    chkReg(A_VAL, 32'h0000FFFF, "R8 free narrow start");
    idle(1);
    chkReg(A_VAL, 32'h0000FFFE, "R8 free narrow decrement");
    idle(65533);
    chkReg(A_VAL, 32'd1, "R8 free narrow near wrap");
    chkReg(A_RAW, 32'd0, "R8 raw clear before wrap");
    idle(1);
    chkReg(A_RAW, 32'd1, "R8 free narrow zero sets raw");
    idle(1);
    chkReg(A_VAL, 32'h0000FFFF, "R8 free narrow wraps to full");

    // Free-running 32-bit
    wr(A_CTRL, 32'hA2);
    chkReg(A_VAL, 32'hFFFFFFFF, "R8 free wide start");
    idle(1);
    chkReg(A_VAL, 32'hFFFFFFFE, "R8 free wide decrement");
    wr(A_LOAD, 32'd7);
    chkReg(A_VAL, 32'hFFFFFFFF, "R8 free ignores stored value");
    chkReg(A_LOAD, 32'd7, "R3 stored value in free mode");

    idle(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule